// File: doc/BRIEF.md
# Dual-Subcarrier Manchester Response Encoder

This block turns a stream of response bytes into the on/off load-modulation pattern a passive tag uses to answer a reader. It runs on the recovered carrier clock, so every duration below is a count of carrier cycles. Each frame opens with a start delimiter, carries the bytes as Manchester-coded bits (least significant bit first, bytes in the order they are accepted), and closes with an end delimiter.

Two subcarrier schemes are available. In single mode the modulated half of a bit is a burst at carrier/32 and the other half is silence of the same length. In dual mode the two halves are bursts at carrier/32 and carrier/28, with `sc_sel` showing which one is active. A low-rate setting stretches every burst and every silent stretch by a factor of four and leaves the subcarrier frequencies unchanged. The mode and rate are sampled once, when the frame starts.

Top module: `uplink_manchester_enc`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mod_en`, `sc_sel` and `in_ready` are all 0.
- R2: A `start` pulse while idle sets `busy` in the following cycle and captures `dual_sel` and `low_rate`. While `busy` is high, `start`, `dual_sel` and `low_rate` have no effect on the output.
- R3: One subcarrier pulse lasts one subcarrier period and is modulated in its first half. At carrier/32, `mod_en` is 1 for 16 cycles and then 0 for 16. At carrier/28 it is 1 for 14 and then 0 for 14. `sc_sel` is 1 exactly during carrier/28 pulses. A silent stretch counts in units of 32 cycles with `mod_en` at 0.
- R4: In single mode, bit 0 is 8 pulses at carrier/32 followed by 256 silent cycles. Bit 1 is the same two halves in the opposite order.
- R5: In dual mode, bit 0 is 8 pulses at carrier/32 followed by 9 pulses at carrier/28. Bit 1 is the same two halves in the opposite order.
- R6: The single-mode start delimiter is 768 silent cycles, then 24 pulses at carrier/32, then a single-mode bit 1.
- R7: The dual-mode start delimiter is 27 pulses at carrier/28, then 24 pulses at carrier/32, then a dual-mode bit 1.
- R8: The end delimiter is a bit 0 in the frame's coding, then 24 pulses at carrier/32, then 768 silent cycles (single mode) or 27 pulses at carrier/28 (dual mode).
- R9: With `low_rate`=1 captured, every pulse count and silent duration in R4 to R8 is four times larger. The subcarrier periods are unchanged.
- R10: `in_ready` is 1 for one cycle: the last cycle of the start delimiter, and the last cycle of each byte's eighth bit. A byte is taken when `in_valid` and `in_ready` are both 1. Its bits follow at once, bit 0 first.
- R11: If `in_valid` is 0 in a cycle where `in_ready` is 1, the end delimiter follows at once. `busy` is 1 through the delimiter's last cycle and 0 in the cycle after, with `mod_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame (honoured only while idle) |
| dual_sel | input | 1 | 1 selects two subcarriers, 0 selects one |
| low_rate | input | 1 | 1 selects the four-times-slower rate |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send, bit 0 first |
| in_ready | output | 1 | Byte taken at this edge when valid |
| mod_en | output | 1 | Load-modulation switch |
| sc_sel | output | 1 | 1 while the carrier/28 subcarrier is active |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `in_valid` and `in_data` hold steady within a cycle. They make no assumption about how long the byte source stalls, because a stall only ends the frame. The stimulus changes inputs only on falling edges. It raises `start` and flips both mode inputs in the middle of every frame, so the properties on captured mode and on idle outputs are exercised while the frame is running.

// File: rtl/upl_pkg.sv
package upl_pkg;

    // burst kinds: silent slot (32 cycles, no modulation), carrier/32, carrier/28
    typedef enum logic [1:0] {
        SK_QUIET = 2'd0,
        SK_FA    = 2'd1,
        SK_FB    = 2'd2
    } seg_kind_e;

    typedef struct packed {
        seg_kind_e  kind;
        logic [4:0] npulse;   // pulse count at high rate
    } seg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOF  = 2'd1,
        PH_DATA = 2'd2,
        PH_EOF  = 2'd3
    } phase_e;

    localparam logic [4:0] HALF_A_PULSES = 5'd8;
    localparam logic [4:0] HALF_B_PULSES = 5'd9;
    localparam logic [4:0] LONG_A_PULSES = 5'd24;
    localparam logic [4:0] LONG_B_PULSES = 5'd27;

    function automatic seg_t mk(seg_kind_e k, logic [4:0] n);
        seg_t s;
        s.kind   = k;
        s.npulse = n;
        return s;
    endfunction

    // half of a bit that is not the carrier/32 burst
    function automatic seg_t other_half(logic dual);
        return dual ? mk(SK_FB, HALF_B_PULSES) : mk(SK_QUIET, HALF_A_PULSES);
    endfunction

    // long delimiter part that is not the carrier/32 burst
    function automatic seg_t other_long(logic dual);
        return dual ? mk(SK_FB, LONG_B_PULSES) : mk(SK_QUIET, LONG_A_PULSES);
    endfunction

    function automatic seg_t seg_lookup(phase_e ph, logic [1:0] idx, logic bitv, logic dual);
        seg_t s;
        s = mk(SK_QUIET, 5'd1);
        case (ph)
            PH_SOF: begin
                case (idx)
                    2'd0:    s = other_long(dual);
                    2'd1:    s = mk(SK_FA, LONG_A_PULSES);
                    2'd2:    s = other_half(dual);
                    default: s = mk(SK_FA, HALF_A_PULSES);
                endcase
            end
            PH_DATA: begin
                if (idx[0] == bitv) s = mk(SK_FA, HALF_A_PULSES);
                else                s = other_half(dual);
            end
            PH_EOF: begin
                case (idx)
                    2'd0:    s = mk(SK_FA, HALF_A_PULSES);
                    2'd1:    s = other_half(dual);
                    2'd2:    s = mk(SK_FA, LONG_A_PULSES);
                    default: s = other_long(dual);
                endcase
            end
            default: s = mk(SK_QUIET, 5'd1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/upl_pulse_timer.sv
module upl_pulse_timer
    import upl_pkg::*;
#(
    parameter int DIV_A    = 32,
    parameter int DIV_B    = 28,
    parameter int MULT_LOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic low_q,
    input  seg_t seg,
    output logic seg_done,
    output logic mod,
    output logic sel
);
    localparam int CW = $clog2(DIV_A);
    localparam int TW = 8;

    logic [CW-1:0] cyc_q;
    logic [TW-1:0] pls_q;
    logic [CW-1:0] period_m1;
    logic [CW-1:0] half_len;
    logic [TW-1:0] total_m1;
    logic          pulse_end;

    always_comb begin
        if (seg.kind == SK_FB) begin
            period_m1 = CW'(DIV_B - 1);
            half_len  = CW'(DIV_B / 2);
        end else begin
            period_m1 = CW'(DIV_A - 1);
            half_len  = CW'(DIV_A / 2);
        end
        if (low_q) total_m1 = TW'(seg.npulse) * TW'(MULT_LOW) - TW'(1);
        else       total_m1 = TW'(seg.npulse) - TW'(1);
    end

    assign pulse_end = (cyc_q == period_m1);
    assign seg_done  = run && pulse_end && (pls_q == total_m1);
    assign mod       = run && (seg.kind != SK_QUIET) && (cyc_q < half_len);
    assign sel       = run && (seg.kind == SK_FB);

    always_ff @(posedge clk) begin
        if (rst || !run || seg_done) begin
            cyc_q <= '0;
            pls_q <= '0;
        end else if (pulse_end) begin
            cyc_q <= '0;
            pls_q <= pls_q + TW'(1);
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end
endmodule

// File: rtl/upl_frame_seq.sv
module upl_frame_seq
    import upl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dual_sel,
    input  logic          low_rate,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          seg_done,
    output logic          in_ready,
    output seg_t          seg,
    output logic          run,
    output logic          dual_q,
    output logic          low_q
);
    localparam int BW = $clog2(DW);

    phase_e        ph_q;
    logic [1:0]    idx_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] sh_q;
    logic          fetch;

    assign run   = (ph_q != PH_IDLE);
    assign seg   = seg_lookup(ph_q, idx_q, sh_q[0], dual_q);
    assign fetch = seg_done &&
                   (((ph_q == PH_SOF) && (idx_q == 2'd3)) ||
                    ((ph_q == PH_DATA) && (idx_q == 2'd1) && (bit_q == BW'(DW - 1))));
    assign in_ready = fetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            idx_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            dual_q <= 1'b0;
            low_q  <= 1'b0;
        end else if (ph_q == PH_IDLE) begin
            if (start) begin
                ph_q   <= PH_SOF;
                idx_q  <= '0;
                dual_q <= dual_sel;
                low_q  <= low_rate;
            end
        end else if (fetch) begin
            idx_q <= '0;
            bit_q <= '0;
            if (in_valid) begin
                ph_q <= PH_DATA;
                sh_q <= in_data;
            end else begin
                ph_q <= PH_EOF;
            end
        end else if (seg_done) begin
            case (ph_q)
                PH_DATA: begin
                    if (idx_q == 2'd0) begin
                        idx_q <= 2'd1;
                    end else begin
                        idx_q <= 2'd0;
                        bit_q <= bit_q + BW'(1);
                        sh_q  <= sh_q >> 1;
                    end
                end
                PH_EOF: begin
                    if (idx_q == 2'd3) ph_q <= PH_IDLE;
                    else               idx_q <= idx_q + 2'd1;
                end
                default: idx_q <= idx_q + 2'd1;
            endcase
        end
    end
endmodule

// File: rtl/uplink_manchester_enc.sv
module uplink_manchester_enc
    import upl_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DIV_A    = 32,
    parameter int DIV_B    = 28,
    parameter int MULT_LOW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dual_sel,
    input  logic          low_rate,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          mod_en,
    output logic          sc_sel,
    output logic          busy
);
    seg_t seg;
    logic seg_done;
    logic run;
    logic dual_q;
    logic low_q;

    upl_frame_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dual_sel (dual_sel),
        .low_rate (low_rate),
        .in_valid (in_valid),
        .in_data  (in_data),
        .seg_done (seg_done),
        .in_ready (in_ready),
        .seg      (seg),
        .run      (run),
        .dual_q   (dual_q),
        .low_q    (low_q)
    );

    upl_pulse_timer #(.DIV_A(DIV_A), .DIV_B(DIV_B), .MULT_LOW(MULT_LOW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .low_q    (low_q),
        .seg      (seg),
        .seg_done (seg_done),
        .mod      (mod_en),
        .sel      (sc_sel)
    );

    assign busy = run;
endmodule

// File: rtl/upl_checks.sv
module upl_checks (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic mod_en,
    input logic sc_sel,
    input logic in_ready,
    input logic dual_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mod_en && !sc_sel && !in_ready));                 // R11
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));                                // R2
    AST_SINGLE_NO_SECOND: assert property (@(posedge clk) disable iff (rst)
        (busy && !dual_q) |-> !sc_sel);                               // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dual_q));                   // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_en) |=> mod_en);                                    // R3
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);                                      // R10
endmodule

bind uplink_manchester_enc upl_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .mod_en   (mod_en),
    .sc_sel   (sc_sel),
    .in_ready (in_ready),
    .dual_q   (dual_q)
);

// File: tb/sim_uplink_manchester_enc.sv
module sim_uplink_manchester_enc;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam int WATCHDOG = 190000;

    // {dual[27], low[26], nbytes[25:24], byte2, byte1, byte0}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd1, 24'h0000A5},
        {1'b1, 1'b0, 2'd2, 24'h00813C},
        {1'b0, 1'b0, 2'd0, 24'h000000},
        {1'b1, 1'b1, 2'd1, 24'h00005A},
        {1'b0, 1'b1, 2'd1, 24'h0000E1},
        {1'b1, 1'b0, 2'd3, 24'hFF00C3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic dual_sel = 1'b0;
    logic low_rate = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, mod_en, sc_sel, busy;

    int n_checks = 0;
    int n_fail = 0;
    int cyc_total = 0;
    int frame_cyc;
    int wave_err;
    int first_bad;
    logic bad_mod, bad_sel, bad_busy, exp_mod_s, exp_sel_s;
    logic [7:0] bq [3];
    int nb, taken;
    logic pend;
    logic cur_dual, cur_low;

    uplink_manchester_enc u0 (
        .clk(clk), .rst(rst), .start(start), .dual_sel(dual_sel),
        .low_rate(low_rate), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mod_en(mod_en), .sc_sel(sc_sel), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_total <= cyc_total + 1;

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic feed_update();
        if (taken < nb) begin
            in_valid = 1'b1;
            in_data  = bq[taken];
        end else begin
            in_valid = 1'b0;
            in_data  = 8'h00;
        end
    endtask

    // one expected cycle: compare at falling edge, then advance
    task automatic step(input logic em, input logic es);
        if ((mod_en !== em || sc_sel !== es || busy !== 1'b1) && wave_err == 0) begin
            first_bad = frame_cyc;
            bad_mod = mod_en; bad_sel = sc_sel; bad_busy = busy;
            exp_mod_s = em; exp_sel_s = es;
        end
        if (mod_en !== em || sc_sel !== es || busy !== 1'b1) wave_err++;
        pend = in_ready && in_valid;
        @(negedge clk);
        frame_cyc++;
        if (pend) begin
            taken++;
            feed_update();
        end
        start = (frame_cyc == 100);   // R2: start while busy
    endtask

    // kind: 0 silent, 1 carrier/32, 2 carrier/28
    task automatic burst(input int kind, input int n);
        int per;
        per = (kind == 2) ? 28 : 32;
        for (int p = 0; p < n * (cur_low ? 4 : 1); p++)
            for (int c = 0; c < per; c++)
                step((kind != 0) && (c < per / 2), kind == 2);
    endtask

    task automatic emit_bit(input logic b);
        if (b) begin
            burst(cur_dual ? 2 : 0, cur_dual ? 9 : 8);
            burst(1, 8);
        end else begin
            burst(1, 8);
            burst(cur_dual ? 2 : 0, cur_dual ? 9 : 8);
        end
    endtask

    task automatic run_frame(input logic [27:0] v);
        string tags;
        cur_dual = v[27];
        cur_low  = v[26];
        nb       = int'(v[25:24]);
        bq[0] = v[7:0]; bq[1] = v[15:8]; bq[2] = v[23:16];
        taken = 0;
        wave_err = 0;
        frame_cyc = 0;
        @(negedge clk);
        feed_update();
        dual_sel = cur_dual;
        low_rate = cur_low;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dual_sel = ~cur_dual;   // R2: mode changes mid-frame ignored
        low_rate = ~cur_low;
        // start delimiter
        burst(cur_dual ? 2 : 0, cur_dual ? 27 : 24);
        burst(1, 24);
        emit_bit(1'b1);
        for (int k = 0; k < nb; k++)
            for (int i = 0; i < 8; i++)
                emit_bit(bq[k][i]);
        // end delimiter
        emit_bit(1'b0);
        burst(1, 24);
        burst(cur_dual ? 2 : 0, cur_dual ? 27 : 24);
        if (cur_dual) tags = cur_low ? "R2 R3 R5 R7 R8 R9 R10" : "R2 R3 R5 R7 R8 R10";
        else          tags = cur_low ? "R2 R3 R4 R6 R8 R9 R10" : "R2 R3 R4 R6 R8 R10";
        if (wave_err != 0)
            $display("  first mismatch cycle %0d: mod=%0b sel=%0b busy=%0b exp mod=%0b sel=%0b busy=1",
                     first_bad, bad_mod, bad_sel, bad_busy, exp_mod_s, exp_sel_s);
        check(wave_err == 0, tags, wave_err, 0);
        check(busy == 1'b0 && mod_en == 1'b0, "R11 busy low after end delimiter",
              int'(busy), 0);
        check(taken == nb, "R10 R11 bytes taken", taken, nb);
    endtask

    initial begin
        @(posedge cyc_total == WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc_total, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && mod_en == 0 && sc_sel == 0 && in_ready == 0,
              "R1 outputs in reset", int'({busy, mod_en, sc_sel, in_ready}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && mod_en == 0 && sc_sel == 0 && in_ready == 0,
              "R1 outputs after reset", int'({busy, mod_en, sc_sel, in_ready}), 0);

        for (int v = 0; v < NVEC; v++) run_frame(VEC[v]);

        // directed: reset in the middle of a frame
        @(negedge clk);
        dual_sel = 1'b1; low_rate = 1'b0; in_valid = 1'b1; in_data = 8'h55;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && sc_sel == 1'b1, "R2 R7 busy and carrier/28 after start",
              int'({busy, sc_sel}), 3);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && mod_en == 0 && sc_sel == 0 && in_ready == 0,
              "R1 reset aborts frame", int'({busy, mod_en, sc_sel, in_ready}), 0);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(busy == 0 && mod_en == 0, "R11 stays idle without start",
              int'({busy, mod_en}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule